// File: doc/BRIEF.md
# Disk Controller Mode Gating and DMA Handshake

This block sits between the core of a floppy-disk controller and its pins. Two configuration bits select one of three operating modes: an AT-style mode, a PS/2-style mode and a Model-30-style mode. The mode decides whether the interrupt and DMA request outputs drive or float, and it sets the active level of the terminal-count input and of the density-select output.

The block also runs the DMA request/acknowledge handshake for the data phase of a transfer command. A request is raised only when DMA was chosen at setup time and a data transfer is running. Each accepted acknowledge selects the FIFO directly, with no address decode, and counts one byte of the current burst. The burst is a parameter in FIFO mode and one byte in byte mode. In byte mode a read can be completed as a pseudo read driven only by acknowledge, which serves a DMA controller that is in verify mode. Terminal count is sampled only under acknowledge and ends the data phase.

Top module: `fdc_mode_gate`

## Requirements
- R1: The mode output reads 0 (AT) when cfg_ident=1 whatever cfg_mfm is, 1 (PS/2) when cfg_ident=0 and cfg_mfm=1, and 2 (Model 30) when both are 0.
- R2: In AT mode irq_oe and drq_oe both equal dma_en, tc_pin is active high and dens_pin equals dens_int.
- R3: In PS/2 mode irq_oe and drq_oe are 1 whatever dma_en is, tc_pin is active low and dens_pin is the inverse of dens_int.
- R4: In Model 30 mode irq_oe and drq_oe both equal dma_en, tc_pin is active high and dens_pin is the inverse of dens_int.
- R5: irq_out equals core_irq AND irq_oe, and drq_out equals the internal request AND drq_oe. The internal request rises one clock after dma_sel, xfer_active and core_req are all 1, and never while dma_sel is 0.
- R6: While the request is active and verify_mode is 0, dack_n=0 sets fifo_sel in the same cycle, with no address input involved.
- R7: The request drops in the cycle after the acknowledge edge that accepts the last byte of a burst. A burst is BURST bytes when fifo_en=1 and one byte when fifo_en=0.
- R8: With verify_mode=1, an acknowledge gives pseudo_rd (and no fifo_sel) only when fifo_en=0 and xfer_read=1. Otherwise the acknowledge is ignored: no strobe fires and no byte is counted.
- R9: tc_done pulses in the same cycle as an accepted acknowledge with terminal count active, and the request drops on the next clock. Terminal count has no effect without acknowledge.
- R10: During and right after reset, drq_out, fifo_sel, pseudo_rd and tc_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ident | input | 1 | Mode configuration bit, 1 selects AT mode |
| cfg_mfm | input | 1 | Mode configuration bit, picks PS/2 or Model 30 mode |
| dma_en | input | 1 | Output-register DMA enable bit |
| dma_sel | input | 1 | DMA chosen by the setup command |
| xfer_active | input | 1 | Data transfer command in execution |
| xfer_read | input | 1 | Active command is a read |
| fifo_en | input | 1 | FIFO enabled (0 = byte mode) |
| verify_mode | input | 1 | DMA controller is in verify mode |
| core_req | input | 1 | Core has data to move |
| core_irq | input | 1 | Core interrupt request |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc_pin | input | 1 | Terminal count pin, level set by mode |
| dens_int | input | 1 | Internal density select, active high |
| mode | output | 2 | Decoded mode: 0 AT, 1 PS/2, 2 Model 30 |
| irq_out | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin drive enable |
| drq_out | output | 1 | DMA request pin data |
| drq_oe | output | 1 | DMA request pin drive enable |
| dens_pin | output | 1 | Density select pin, level set by mode |
| fifo_sel | output | 1 | FIFO access strobe from acknowledge |
| pseudo_rd | output | 1 | Pseudo read strobe in byte-mode verify |
| tc_done | output | 1 | Terminal count ended execution |

## Verification
The bench runs all three modes with dma_en both set and cleared. A decode that mixes up the two low-IDENT modes would float the pins in PS/2 mode or invert the wrong pin. It counts acknowledges across a FIFO burst and a byte-mode burst, so an off-by-one counter shows up as a request that drops a byte early or late. It gives verify acknowledges with the FIFO enabled, where a design that counted them would end the burst. It drives terminal count without acknowledge and at the inactive level in each polarity, where a design that sampled it loosely would end execution at the wrong time.

// File: rtl/fdc_mode_pkg.sv
package fdc_mode_pkg;
  typedef enum logic [1:0] {
    MODE_AT  = 2'd0,
    MODE_PS2 = 2'd1,
    MODE_M30 = 2'd2
  } mode_t;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_REQ  = 1'b1
  } hs_state_t;
endpackage

// File: rtl/fdc_mode_decode.sv
module fdc_mode_decode
  import fdc_mode_pkg::*;
(
  input  logic  cfg_ident,
  input  logic  cfg_mfm,
  input  logic  dma_en,
  input  logic  tc_pin,
  input  logic  dens_int,
  output mode_t mode,
  output logic  out_en,
  output logic  tc_act,
  output logic  dens_pin
);
  always_comb begin
    if (cfg_ident)    mode = MODE_AT;
    else if (cfg_mfm) mode = MODE_PS2;
    else              mode = MODE_M30;
  end

  always_comb begin
    out_en   = dma_en;
    tc_act   = tc_pin;
    dens_pin = ~dens_int;
    unique case (mode)
      MODE_AT: begin
        dens_pin = dens_int;
      end
      MODE_PS2: begin
        out_en = 1'b1;
        tc_act = ~tc_pin;
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_decode_onehot_R1: assert (mode != 2'd3);
  end
endmodule

// File: rtl/fdc_dma_hs.sv
module fdc_dma_hs
  import fdc_mode_pkg::*;
#(
  parameter int BURST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_sel,
  input  logic xfer_active,
  input  logic xfer_read,
  input  logic fifo_en,
  input  logic verify_mode,
  input  logic core_req,
  input  logic dack_n,
  input  logic tc_act,
  output logic drq,
  output logic fifo_sel,
  output logic pseudo_rd,
  output logic tc_done
);
  localparam int CW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [CW-1:0] LAST_FIFO = CW'(BURST - 1);

  hs_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_idx;
  logic          ack, accept, burst_end;

  assign ack       = ~dack_n & (state_q == HS_REQ);
  assign fifo_sel  = ack & ~verify_mode;
  assign pseudo_rd = ack & verify_mode & ~fifo_en & xfer_read;
  assign accept    = fifo_sel | pseudo_rd;
  assign tc_done   = accept & tc_act;
  assign last_idx  = fifo_en ? LAST_FIFO : '0;
  assign burst_end = accept & (cnt_q == last_idx);
  assign drq       = (state_q == HS_REQ);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      HS_IDLE: begin
        cnt_d = '0;
        if (dma_sel && xfer_active && core_req) state_d = HS_REQ;
      end
      HS_REQ: begin
        if (!xfer_active || tc_done || burst_end) begin
          state_d = HS_IDLE;
          cnt_d   = '0;
        end else if (accept) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_req_needs_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> $past(dma_sel && xfer_active && core_req));
  assert_fifo_sel_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_sel |-> (!dack_n && drq));
  assert_drop_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !drq);
  assert_pseudo_byte_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pseudo_rd |-> (!fifo_en && xfer_read && !fifo_sel));
  assert_tc_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_done |=> !drq);
  assert_tc_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_done |-> !dack_n);
endmodule

// File: rtl/fdc_mode_gate.sv
module fdc_mode_gate
  import fdc_mode_pkg::*;
#(
  parameter int BURST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_ident,
  input  logic       cfg_mfm,
  input  logic       dma_en,
  input  logic       dma_sel,
  input  logic       xfer_active,
  input  logic       xfer_read,
  input  logic       fifo_en,
  input  logic       verify_mode,
  input  logic       core_req,
  input  logic       core_irq,
  input  logic       dack_n,
  input  logic       tc_pin,
  input  logic       dens_int,
  output logic [1:0] mode,
  output logic       irq_out,
  output logic       irq_oe,
  output logic       drq_out,
  output logic       drq_oe,
  output logic       dens_pin,
  output logic       fifo_sel,
  output logic       pseudo_rd,
  output logic       tc_done
);
  logic  rst_meta, rst_sync_n;
  mode_t mode_dec;
  logic  out_en, tc_act, drq_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fdc_mode_decode u_decode (
    .cfg_ident (cfg_ident),
    .cfg_mfm   (cfg_mfm),
    .dma_en    (dma_en),
    .tc_pin    (tc_pin),
    .dens_int  (dens_int),
    .mode      (mode_dec),
    .out_en    (out_en),
    .tc_act    (tc_act),
    .dens_pin  (dens_pin)
  );

  fdc_dma_hs #(.BURST(BURST)) u_hs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .dma_sel     (dma_sel),
    .xfer_active (xfer_active),
    .xfer_read   (xfer_read),
    .fifo_en     (fifo_en),
    .verify_mode (verify_mode),
    .core_req    (core_req),
    .dack_n      (dack_n),
    .tc_act      (tc_act),
    .drq         (drq_int),
    .fifo_sel    (fifo_sel),
    .pseudo_rd   (pseudo_rd),
    .tc_done     (tc_done)
  );

  assign mode    = mode_dec;
  assign irq_oe  = out_en;
  assign drq_oe  = out_en;
  assign irq_out = core_irq & out_en;
  assign drq_out = drq_int & out_en;

  assert_ps2_drives_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_ident && cfg_mfm) |-> (irq_oe && drq_oe));
  assert_gated_modes_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_ident || !cfg_mfm) |-> (irq_oe == dma_en && drq_oe == dma_en));
  assert_drq_gated_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drq_out |-> drq_oe);
endmodule

// File: tb/fdc_mode_gate_bench.sv
module fdc_mode_gate_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_ident, cfg_mfm, dma_en, dma_sel, xfer_active, xfer_read;
  logic fifo_en, verify_mode, core_req, core_irq, dack_n, tc_pin, dens_int;
  logic [1:0] mode;
  logic irq_out, irq_oe, drq_out, drq_oe, dens_pin, fifo_sel, pseudo_rd, tc_done;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fdc_mode_gate #(.BURST(4)) u_fdc_mode_gate (.*);

  // {ident, mfm, dma_en, dens_int, exp_mode[1:0], exp_oe, exp_dens_pin}
  localparam logic [7:0] VEC [8] = '{
    8'b1011_0011, 8'b1100_0000, 8'b0101_0110, 8'b0110_0111,
    8'b0011_1010, 8'b0000_1001, 8'b1001_0001, 8'b0010_1011
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_ident = 1; cfg_mfm = 0; dma_en = 1; dma_sel = 0;
    xfer_active = 0; xfer_read = 0; fifo_en = 1; verify_mode = 0;
    core_req = 0; core_irq = 1; dack_n = 1; tc_pin = 0; dens_int = 0;
    step(); step();
    chk("R10 drq", {1'b0, drq_out}, 2'd0);
    chk("R10 strobes", {fifo_sel, pseudo_rd | tc_done}, 2'd0);
    rst_n = 1;
    step(); step(); step();
    chk("R10 drq after release", {1'b0, drq_out}, 2'd0);

    for (int i = 0; i < 8; i++) begin
      {cfg_ident, cfg_mfm, dma_en, dens_int} = VEC[i][7:4];
      #1;
      chk("R1 mode", mode, VEC[i][3:2]);
      chk((VEC[i][3:2] == 2'd1) ? "R3 oe" : "R2/R4 oe", {irq_oe, drq_oe}, {2{VEC[i][1]}});
      chk("R5 irq_out", {1'b0, irq_out}, {1'b0, VEC[i][1]});
      chk((VEC[i][3:2] == 2'd0) ? "R2 dens" : "R3/R4 dens", {1'b0, dens_pin}, {1'b0, VEC[i][0]});
    end

    // AT mode, outputs enabled
    cfg_ident = 1; cfg_mfm = 0; dma_en = 1;
    xfer_active = 1; core_req = 1; dma_sel = 0;
    step(); step();
    chk("R5 no drq without dma_sel", {1'b0, drq_out}, 2'd0);
    dma_sel = 1;
    step();
    chk("R5 drq raised", {1'b0, drq_out}, 2'd1);
    dack_n = 0; #1;
    chk("R6 fifo_sel on ack", {1'b0, fifo_sel}, 2'd1);
    step(); step(); step();
    chk("R7 drq held before last byte", {1'b0, drq_out}, 2'd1);
    step();
    chk("R7 drq dropped after burst", {1'b0, drq_out}, 2'd0);
    dack_n = 1;
    step();
    chk("R7 re-request", {1'b0, drq_out}, 2'd1);

    fifo_en = 0; dack_n = 0;
    step();
    chk("R7 byte mode one-byte burst", {1'b0, drq_out}, 2'd0);
    dack_n = 1; step();

    verify_mode = 1; xfer_read = 1; dack_n = 0; #1;
    chk("R8 pseudo read", {pseudo_rd, fifo_sel}, 2'b10);
    step();
    chk("R8 pseudo read counted", {1'b0, drq_out}, 2'd0);
    dack_n = 1; step();

    fifo_en = 1; dack_n = 0; #1;
    chk("R8 verify with FIFO ignored", {pseudo_rd, fifo_sel}, 2'b00);
    step(); step(); step(); step(); step();
    chk("R8 ignored ack not counted", {1'b0, drq_out}, 2'd1);
    dack_n = 1; verify_mode = 0;

    tc_pin = 1; step();
    chk("R9 tc without ack", {tc_done, drq_out}, 2'b01);
    dack_n = 0; #1;
    chk("R9 tc with ack", {1'b0, tc_done}, 2'd1);
    step();
    chk("R9 drq dropped after tc", {1'b0, drq_out}, 2'd0);
    dack_n = 1; tc_pin = 1;

    // PS/2 mode: TC active low, pins drive whatever dma_en is
    cfg_ident = 0; cfg_mfm = 1; dma_en = 0;
    step();
    chk("R3 drq drives with dma_en=0", {1'b0, drq_out}, 2'd1);
    dack_n = 0; #1;
    chk("R3 tc high inactive", {1'b0, tc_done}, 2'd0);
    tc_pin = 0; #1;
    chk("R3 tc low active", {1'b0, tc_done}, 2'd1);
    step();
    dack_n = 1; tc_pin = 0;

    // Model 30 mode: gated pins, TC active high
    cfg_ident = 0; cfg_mfm = 0; dma_en = 0;
    step();
    chk("R4 drq gated", {drq_out, irq_out}, 2'b00);
    dma_en = 1; #1;
    chk("R4 drq enabled", {drq_out, irq_out}, 2'b11);
    dack_n = 0; tc_pin = 1; #1;
    chk("R4 tc high active", {1'b0, tc_done}, 2'd1);
    step();
    dack_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule